// File: doc/BRIEF.md
# Column-Associative Read Cache

This block is a direct-mapped read cache in which every set is paired with one backup set. The backup index is the normal index with its top bit inverted. A lookup first reads the normal (primary) frame. If that misses and the primary frame holds a line that belongs there, the block reads the backup (secondary) frame in a second cycle. Each frame carries a rehash flag. The flag marks a line that sits in the frame of its partner index. The flag decides whether the second read is worth making, and which line gives way on a fill.

A hit in the primary frame answers one cycle after the request is accepted. A hit in the secondary frame answers after three cycles: one cycle for each probe, then one cycle in which the two lines trade places. After the trade, the line just used sits in its primary frame. On a full miss, the block asks memory for the line through a request/valid fill handshake, installs the line and returns it as a miss response. A separate prefetch input can drop a line into a frame whose current content is expendable, without any memory request.

The controller has five states. IDLE accepts requests and prefetches. PROBE2 reads the secondary frame. SWAP exchanges the primary and secondary lines. FETCH waits for the fill. RESP presents the response for one cycle. The transitions are:
- IDLE→RESP on a primary hit.
- IDLE→FETCH when the primary frame is invalid or rehashed.
- IDLE→PROBE2 otherwise.
- PROBE2→SWAP on a secondary hit.
- PROBE2→FETCH on a secondary miss.
- SWAP→RESP.
- FETCH→RESP when the fill arrives.
- RESP→IDLE.

Top module: `colassoc_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `fill_req` are 0. Every frame is invalid, so the first lookup of any address is a miss.
- R2: A lookup whose line is in its primary frame gives `rsp_valid` with `rsp_hit`=1 and the line's data exactly one cycle after acceptance. `rsp_valid` lasts one cycle.
- R3: The secondary index is the primary index (the low IDX_W bits of the line address) with its most significant bit inverted. A lookup found there gives a hit with its data three cycles after acceptance.
- R4: A hit in the secondary frame swaps the two lines. The requested line moves to the primary frame with the rehash flag clear, so its next lookup hits in one cycle. The former primary line moves to the secondary frame with the rehash flag set, so its next lookup takes three cycles.
- R5: If the primary frame is invalid or has its rehash flag set, a primary miss skips the second probe. `fill_req` rises one cycle after acceptance, and the fetched line overwrites the primary frame, evicting the rehashed line.
- R6: If the primary frame holds a non-rehashed line and both probes miss, `fill_req` rises two cycles after acceptance. The new line goes into the primary frame. The old primary line moves to the secondary frame with its rehash flag set. The old secondary line is evicted.
- R7: While `fill_req` is high, `fill_addr` equals the requested line address and stays stable until `fill_valid`. One cycle after `fill_valid`, `rsp_valid` is 1 with `rsp_hit`=0 and `rsp_data` equal to the fill data. `req_ready` is 0 from acceptance until the response has been given.
- R8: A prefetch is accepted in IDLE and placed in one cycle. If the line is already present, the prefetch is dropped. Otherwise it goes to the primary frame (flag clear) if that frame is invalid or rehashed. Failing that, it goes to the secondary frame (flag set) if that frame is invalid or rehashed. Failing both, it is dropped.
- R9: A request and a prefetch in the same cycle: the request wins, `pf_ready` is 0, and the prefetch is not placed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Line address to look up |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_hit | output | 1 | 1 = hit, 0 = miss served by a fill |
| rsp_data | output | DATA_W | Line data of the response |
| fill_req | output | 1 | Line fetch request to memory |
| fill_addr | output | ADDR_W | Line address to fetch |
| fill_valid | input | 1 | Fill data present |
| fill_data | input | DATA_W | Fetched line data |
| pf_valid | input | 1 | Prefetch line offered |
| pf_ready | output | 1 | Prefetch taken this cycle |
| pf_addr | input | ADDR_W | Prefetch line address |
| pf_data | input | DATA_W | Prefetch line data |

## Verification
A primary hit answers one cycle after acceptance and a secondary hit answers three cycles after acceptance. On a miss, `fill_req` appears one cycle after acceptance when the second probe is skipped and two cycles after when it is made. The miss response follows `fill_valid` by one cycle. Inputs are driven and outputs sampled on the falling edge. The bench counts rising edges from acceptance and compares the cycle in which `fill_req` and `rsp_valid` first appear against these figures. Prefetch placement and eviction cannot be seen directly, so they are judged from the latency and data of later lookups.

// File: rtl/cac_pkg.sv
package cac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE2,
        ST_SWAP,
        ST_FETCH,
        ST_RESP
    } cac_state_e;
endpackage

// File: rtl/cac_frames.sv
// Frame storage: one read/write port at the primary index, one at its partner.
module cac_frames #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  p_idx,
    input  logic [IDX_W-1:0]  s_idx,
    output logic              p_valid,
    output logic              p_reh,
    output logic [TAG_W-1:0]  p_tag,
    output logic [DATA_W-1:0] p_data,
    output logic              s_valid,
    output logic              s_reh,
    output logic [TAG_W-1:0]  s_tag,
    output logic [DATA_W-1:0] s_data,
    input  logic              wp_en,
    input  logic              wp_reh,
    input  logic [TAG_W-1:0]  wp_tag,
    input  logic [DATA_W-1:0] wp_data,
    input  logic              ws_en,
    input  logic              ws_reh,
    input  logic [TAG_W-1:0]  ws_tag,
    input  logic [DATA_W-1:0] ws_data
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   reh_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            reh_q   <= '0;
        end else begin
            if (wp_en) begin
                valid_q[p_idx] <= 1'b1;
                reh_q[p_idx]   <= wp_reh;
            end
            if (ws_en) begin
                valid_q[s_idx] <= 1'b1;
                reh_q[s_idx]   <= ws_reh;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wp_en) begin
            tag_q[p_idx]  <= wp_tag;
            data_q[p_idx] <= wp_data;
        end
        if (ws_en) begin
            tag_q[s_idx]  <= ws_tag;
            data_q[s_idx] <= ws_data;
        end
    end

    assign p_valid = valid_q[p_idx];
    assign p_reh   = reh_q[p_idx];
    assign p_tag   = tag_q[p_idx];
    assign p_data  = data_q[p_idx];
    assign s_valid = valid_q[s_idx];
    assign s_reh   = reh_q[s_idx];
    assign s_tag   = tag_q[s_idx];
    assign s_data  = data_q[s_idx];
endmodule

// File: rtl/cac_ctrl.sv
// Lookup controller: probe sequencing, swap, fill and prefetch placement.
module cac_ctrl
    import cac_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = ADDR_W - IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              pf_valid,
    output logic              pf_ready,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic [DATA_W-1:0] pf_data,
    output logic [IDX_W-1:0]  p_idx,
    output logic [IDX_W-1:0]  s_idx,
    input  logic              p_valid,
    input  logic              p_reh,
    input  logic [TAG_W-1:0]  p_tag,
    input  logic [DATA_W-1:0] p_data,
    input  logic              s_valid,
    input  logic              s_reh,
    input  logic [TAG_W-1:0]  s_tag,
    input  logic [DATA_W-1:0] s_data,
    output logic              wp_en,
    output logic              wp_reh,
    output logic [TAG_W-1:0]  wp_tag,
    output logic [DATA_W-1:0] wp_data,
    output logic              ws_en,
    output logic              ws_reh,
    output logic [TAG_W-1:0]  ws_tag,
    output logic [DATA_W-1:0] ws_data
);
    localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(1) << (IDX_W - 1);

    cac_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              two_probe_q;
    logic              rsp_hit_q;
    logic [DATA_W-1:0] rsp_data_q;

    logic [ADDR_W-1:0] look_addr;
    logic [TAG_W-1:0]  look_tag;
    logic              p_match, s_match;
    logic              p_spare, s_spare;

    // The tag keeps the top index bit so a line is recognised in either frame.
    always_comb begin
        if (state_q == ST_IDLE) look_addr = req_valid ? req_addr : pf_addr;
        else                    look_addr = addr_q;
    end
    assign look_tag = look_addr[ADDR_W-1:IDX_W-1];
    assign p_idx    = look_addr[IDX_W-1:0];
    assign s_idx    = look_addr[IDX_W-1:0] ^ TOP_BIT;
    assign p_match  = p_valid && (p_tag == look_tag);
    assign s_match  = s_valid && (s_tag == look_tag);
    assign p_spare  = !p_valid || p_reh;
    assign s_spare  = !s_valid || s_reh;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (p_match)      state_d = ST_RESP;
                    else if (p_spare) state_d = ST_FETCH;
                    else              state_d = ST_PROBE2;
                end
            end
            ST_PROBE2: state_d = s_match ? ST_SWAP : ST_FETCH;
            ST_SWAP:   state_d = ST_RESP;
            ST_FETCH:  state_d = fill_valid ? ST_RESP : ST_FETCH;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and frame writes
    always_comb begin
        req_ready = 1'b0;
        pf_ready  = 1'b0;
        rsp_valid = 1'b0;
        fill_req  = 1'b0;
        wp_en     = 1'b0;
        wp_reh    = 1'b0;
        wp_tag    = look_tag;
        wp_data   = fill_data;
        ws_en     = 1'b0;
        ws_reh    = 1'b1;
        ws_tag    = p_tag;
        ws_data   = p_data;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                pf_ready  = !req_valid;
                if (!req_valid && pf_valid && !p_match && !s_match) begin
                    wp_data = pf_data;
                    ws_tag  = look_tag;
                    ws_data = pf_data;
                    if (p_spare)      wp_en = 1'b1;
                    else if (s_spare) ws_en = 1'b1;
                end
            end
            ST_PROBE2: ;
            ST_SWAP: begin
                wp_en   = 1'b1;
                wp_tag  = s_tag;
                wp_data = s_data;
                ws_en   = 1'b1;
            end
            ST_FETCH: begin
                fill_req = 1'b1;
                wp_en    = fill_valid;
                ws_en    = fill_valid && two_probe_q;
            end
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    // Request and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            two_probe_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q      <= req_addr;
                        two_probe_q <= 1'b0;
                        rsp_hit_q   <= 1'b1;
                        rsp_data_q  <= p_data;
                    end
                end
                ST_PROBE2: two_probe_q <= 1'b1;
                ST_SWAP: begin
                    rsp_hit_q  <= 1'b1;
                    rsp_data_q <= s_data;
                end
                ST_FETCH: begin
                    if (fill_valid) begin
                        rsp_hit_q  <= 1'b0;
                        rsp_data_q <= fill_data;
                    end
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    assign rsp_hit   = rsp_hit_q;
    assign rsp_data  = rsp_data_q;
    assign fill_addr = addr_q;
endmodule

// File: rtl/colassoc_cache.sv
module colassoc_cache #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              pf_valid,
    output logic              pf_ready,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic [DATA_W-1:0] pf_data
);
    localparam int TAG_W = ADDR_W - IDX_W + 1;

    logic [IDX_W-1:0]  p_idx, s_idx;
    logic              p_valid, p_reh, s_valid, s_reh;
    logic [TAG_W-1:0]  p_tag, s_tag;
    logic [DATA_W-1:0] p_data, s_data;
    logic              wp_en, wp_reh, ws_en, ws_reh;
    logic [TAG_W-1:0]  wp_tag, ws_tag;
    logic [DATA_W-1:0] wp_data, ws_data;

    cac_ctrl #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_data(pf_data),
        .p_idx(p_idx), .s_idx(s_idx),
        .p_valid(p_valid), .p_reh(p_reh), .p_tag(p_tag), .p_data(p_data),
        .s_valid(s_valid), .s_reh(s_reh), .s_tag(s_tag), .s_data(s_data),
        .wp_en(wp_en), .wp_reh(wp_reh), .wp_tag(wp_tag), .wp_data(wp_data),
        .ws_en(ws_en), .ws_reh(ws_reh), .ws_tag(ws_tag), .ws_data(ws_data)
    );

    cac_frames #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) frames_i (
        .clk(clk), .rst_n(rst_n),
        .p_idx(p_idx), .s_idx(s_idx),
        .p_valid(p_valid), .p_reh(p_reh), .p_tag(p_tag), .p_data(p_data),
        .s_valid(s_valid), .s_reh(s_reh), .s_tag(s_tag), .s_data(s_data),
        .wp_en(wp_en), .wp_reh(wp_reh), .wp_tag(wp_tag), .wp_data(wp_data),
        .ws_en(ws_en), .ws_reh(ws_reh), .ws_tag(ws_tag), .ws_data(ws_data)
    );
endmodule

// File: rtl/cac_checker.sv
module cac_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              fill_req,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              pf_ready
);
    // The only response one cycle after acceptance is a primary hit
    assert_fast_rsp_is_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!rsp_valid || rsp_hit));

    assert_rsp_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_fill_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

    assert_fill_gives_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_valid) |=> (rsp_valid && !rsp_hit));

    assert_busy_when_serving_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !fill_req));

    assert_req_beats_pf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !pf_ready);
endmodule

bind colassoc_cache cac_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .fill_req(fill_req),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .pf_ready(pf_ready)
);

// File: tb/colassoc_cache_tb_top.sv
module colassoc_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [DW-1:0] rsp_data;
    logic          fill_req;
    logic [AW-1:0] fill_addr;
    logic          fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;
    logic          pf_valid = 1'b0;
    logic          pf_ready;
    logic [AW-1:0] pf_addr = '0;
    logic [DW-1:0] pf_data = '0;

    int nvec = 0;
    int nfail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    colassoc_cache #(.ADDR_W(AW), .IDX_W(4), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_data(pf_data)
    );

    function automatic logic [DW-1:0] fdat(input logic [AW-1:0] a);
        return 32'hF000_0000 | DW'(a);
    endfunction
    function automatic logic [DW-1:0] pdat(input logic [AW-1:0] a);
        return 32'hB000_0000 | DW'(a);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // One lookup; serves any fill at once and checks timing and result.
    task automatic lookup(input logic [AW-1:0] a, input bit exp_hit, input int exp_fill,
                          input int exp_lat, input logic [DW-1:0] exp_data, input string rq);
        int n = 0;
        int fseen = 0;
        bit done = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        chk(req_ready == 1'b0, "R7", "ready while busy", 64'(req_ready), 0);
        while (!done && n < 40) begin
            if (fill_req && fseen == 0) begin
                fseen = n;
                chk(fill_addr == a, "R7", "fill address", 64'(fill_addr), 64'(a));
                fill_valid = 1'b1;
                fill_data  = fdat(a);
                @(negedge clk);
                fill_valid = 1'b0;
                n++;
            end else if (rsp_valid) begin
                done = 1;
            end else begin
                @(negedge clk);
                n++;
            end
        end
        chk(done, rq, "response seen", 64'(done), 1);
        chk(fseen == exp_fill, rq, "fill request cycle", 64'(fseen), 64'(exp_fill));
        chk(n == exp_lat, rq, "response cycle", 64'(n), 64'(exp_lat));
        chk(rsp_hit == exp_hit, rq, "hit flag", 64'(rsp_hit), 64'(exp_hit));
        chk(rsp_data == exp_data, rq, "data", 64'(rsp_data), 64'(exp_data));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", "response one cycle", 64'(rsp_valid), 0);
    endtask

    task automatic prefetch(input logic [AW-1:0] a, input string rq);
        @(negedge clk);
        pf_valid = 1'b1;
        pf_addr  = a;
        pf_data  = pdat(a);
        #1;
        chk(pf_ready == 1'b1, rq, "prefetch taken", 64'(pf_ready), 1);
        @(negedge clk);
        pf_valid = 1'b0;
    endtask

    task automatic test_reset();
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", 64'(rsp_valid), 0);
        chk(fill_req == 1'b0, "R1", "no fill after reset", 64'(fill_req), 0);
        lookup(12'h002, 0, 1, 2, fdat(12'h002), "R1");
    endtask

    task automatic test_primary_and_swap();
        lookup(12'h002, 1, 0, 1, fdat(12'h002), "R2");
        lookup(12'h102, 0, 2, 3, fdat(12'h102), "R6");   // two probes, old line to idx 10
        lookup(12'h102, 1, 0, 1, fdat(12'h102), "R6");
        lookup(12'h002, 1, 0, 3, fdat(12'h002), "R3");   // found at index 2^8
        lookup(12'h002, 1, 0, 1, fdat(12'h002), "R4");
        lookup(12'h102, 1, 0, 3, fdat(12'h102), "R4");
    endtask

    task automatic test_evictions();
        lookup(12'h202, 0, 2, 3, fdat(12'h202), "R6");
        lookup(12'h002, 0, 2, 3, fdat(12'h002), "R6");   // old secondary was evicted
        lookup(12'h00A, 0, 1, 2, fdat(12'h00A), "R5");   // frame 10 rehashed: no probe 2
        lookup(12'h202, 0, 2, 3, fdat(12'h202), "R5");   // rehashed line evicted
    endtask

    task automatic test_prefetch();
        prefetch(12'h005, "R8");
        lookup(12'h005, 1, 0, 1, pdat(12'h005), "R8");
        prefetch(12'h105, "R8");
        lookup(12'h105, 1, 0, 3, pdat(12'h105), "R8");
        prefetch(12'h205, "R8");                          // lands on rehashed secondary
        lookup(12'h205, 1, 0, 3, pdat(12'h205), "R8");
        lookup(12'h005, 0, 2, 3, fdat(12'h005), "R8");
        lookup(12'h006, 0, 1, 2, fdat(12'h006), "R8");
        lookup(12'h00E, 0, 1, 2, fdat(12'h00E), "R8");
        prefetch(12'h006, "R8");                          // already present: dropped
        lookup(12'h006, 1, 0, 1, fdat(12'h006), "R8");
        prefetch(12'h106, "R8");                          // no spare frame: dropped
        lookup(12'h106, 0, 2, 3, fdat(12'h106), "R8");
    endtask

    task automatic test_priority();
        int n = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 12'h003;
        pf_valid  = 1'b1;
        pf_addr   = 12'h007;
        pf_data   = pdat(12'h007);
        #1;
        chk(pf_ready == 1'b0, "R9", "prefetch refused", 64'(pf_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        pf_valid  = 1'b0;
        while (!fill_req && n < 20) begin
            @(negedge clk);
            n++;
        end
        fill_valid = 1'b1;
        fill_data  = fdat(12'h003);
        @(negedge clk);
        fill_valid = 1'b0;
        chk(rsp_valid && !rsp_hit && rsp_data == fdat(12'h003), "R9", "request served",
            64'(rsp_data), 64'(fdat(12'h003)));
        lookup(12'h007, 0, 1, 2, fdat(12'h007), "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_primary_and_swap();
        test_evictions();
        test_prefetch();
        test_priority();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            nvec++;
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule